// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Flush on Disable

This block receives asynchronous serial characters on one input line. It runs from a clock enable that pulses sixteen times per bit period. Each frame has a start bit, then 5 to 9 data bits sent least significant bit first, then an optional parity bit and a stop bit. Every completed character goes into a small receive queue together with its ninth bit, its framing status and its parity status. A host side reads the queue through a simple pop strobe.

While the enable input is high, the receiver claims the serial pin from general-purpose use. When enable drops, the block empties the queue, clears the overrun indication and returns the frame sampler to idle. All status outputs then read zero. The ninth data bit is shown on its own output and describes the character at the head of the queue. Software has to capture it before it strobes the low-byte read, because that strobe retires the head entry.

Top module: `serial_rx_unit`

## Requirements
- R1: A falling edge on `rx_line` starts a frame only if the line still reads low eight ticks later, at the middle of the start bit. A shorter low pulse produces no character.
- R2: `size_code` selects the number of data bits: 0 gives 5, 1 gives 6, 2 gives 7, 3 gives 8 and 7 gives 9, and any other code gives 8. Bits arrive least significant first and are right-aligned in the stored character. Bits above the character size read as zero. Each data bit is sampled sixteen ticks after the previous sample point.
- R3: `parity_sel` value 2 expects even parity and value 3 expects odd parity, with the parity bit following the data bits. Values 0 and 1 mean no parity bit. `parity_err` of the head entry is 1 exactly when parity is enabled and the received parity bit does not match the data.
- R4: `frame_err` of the head entry is 1 exactly when the stop bit sampled 0.
- R5: The queue holds `QUEUE_DEPTH` (default 2) characters. `rx_ready` is high exactly while the queue holds at least one unread character.
- R6: `rx_byte` shows the low 8 bits of the head character, and `rx_bit8` shows its ninth bit. A one-cycle `rd_pop` pulse while `rx_ready` is high retires the head entry. A pulse while the queue is empty has no effect.
- R7: If a frame completes while the queue is full, that frame is dropped and `overrun` goes high. `overrun` stays high until the next pop or until the block is disabled.
- R8: While `rx_enable` is low, the queue is emptied and the sampler stays idle. `rx_ready`, `rx_byte`, `rx_bit8`, `frame_err`, `parity_err` and `overrun` then all read 0.
- R9: `pin_claimed` equals `rx_enable`, so the receiver owns the serial pin exactly while it is enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | Clock enable, sixteen pulses per bit |
| rx_line | input | 1 | Serial input, idle high |
| rx_enable | input | 1 | Receiver enable; low flushes |
| size_code | input | 3 | Character size code |
| parity_sel | input | 2 | Parity mode |
| rd_pop | input | 1 | Low-byte read strobe, retires head |
| rx_byte | output | 8 | Head character, bits 7..0 |
| rx_bit8 | output | 1 | Head character, bit 8 |
| frame_err | output | 1 | Head entry framing status |
| parity_err | output | 1 | Head entry parity status |
| overrun | output | 1 | A frame was dropped on a full queue |
| rx_ready | output | 1 | Queue not empty |
| pin_claimed | output | 1 | Receiver owns the serial pin |

## Verification
The properties assume three things about the inputs: `rd_pop` pulses last a single cycle, `size_code` and `parity_sel` change only while the line is idle between frames, and `os_tick` is never high on two cycles in a row. The stimulus meets all three. It changes configuration only after the stop bit plus a full idle bit, it drives each pop for one cycle, and it produces the tick from a divider on the clock. Random characters, sizes, parity modes and injected parity or stop faults are mixed with directed glitch, overrun and disable cases.

// File: rtl/srx_pkg.sv
package srx_pkg;

  typedef struct packed {
    logic [8:0] chr;
    logic       ferr;
    logic       perr;
  } srx_entry_t;

  function automatic logic [3:0] char_width(input logic [2:0] code);
    case (code)
      3'd0:    char_width = 4'd5;
      3'd1:    char_width = 4'd6;
      3'd2:    char_width = 4'd7;
      3'd7:    char_width = 4'd9;
      default: char_width = 4'd8;
    endcase
  endfunction

endpackage

// File: rtl/srx_sampler.sv
module srx_sampler
  import srx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       tick,
  input  logic       line_in,
  input  logic [2:0] size_code,
  input  logic [1:0] parity_sel,
  output logic       done,
  output srx_entry_t result
);

  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] MID  = CW'(OSR/2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  st_t           st_q, st_d;
  logic [CW-1:0] sub_q, sub_d;
  logic [3:0]    bit_q, bit_d;
  logic [8:0]    sh_q, sh_d;
  logic          par_q, par_d;
  logic          done_q, done_d;
  srx_entry_t    res_q, res_d;
  logic          sy1_q, sy2_q, prev_q;

  logic       fall;
  logic [3:0] nbits;
  logic       par_on;
  logic [8:0] aligned;
  logic       par_exp;

  assign fall    = prev_q & ~sy2_q;
  assign nbits   = char_width(size_code);
  assign par_on  = parity_sel[1];
  assign aligned = sh_q >> (4'd9 - nbits);
  assign par_exp = (^aligned) ^ parity_sel[0];

  always_comb begin
    st_d   = st_q;
    sub_d  = sub_q;
    bit_d  = bit_q;
    sh_d   = sh_q;
    par_d  = par_q;
    done_d = 1'b0;
    res_d  = res_q;
    case (st_q)
      S_IDLE: begin
        if (fall) begin
          st_d  = S_START;
          sub_d = '0;
        end
      end
      S_START: begin
        if (tick) begin
          if (sub_q == MID) begin
            sub_d = '0;
            bit_d = '0;
            sh_d  = '0;
            st_d  = sy2_q ? S_IDLE : S_DATA;
          end else begin
            sub_d = sub_q + 1'b1;
          end
        end
      end
      S_DATA: begin
        if (tick) begin
          if (sub_q == LAST) begin
            sub_d = '0;
            sh_d  = {sy2_q, sh_q[8:1]};
            if (bit_q == nbits - 4'd1) begin
              st_d = par_on ? S_PAR : S_STOP;
            end else begin
              bit_d = bit_q + 4'd1;
            end
          end else begin
            sub_d = sub_q + 1'b1;
          end
        end
      end
      S_PAR: begin
        if (tick) begin
          if (sub_q == LAST) begin
            sub_d = '0;
            par_d = sy2_q;
            st_d  = S_STOP;
          end else begin
            sub_d = sub_q + 1'b1;
          end
        end
      end
      S_STOP: begin
        if (tick) begin
          if (sub_q == LAST) begin
            done_d     = 1'b1;
            res_d.chr  = aligned;
            res_d.ferr = ~sy2_q;
            res_d.perr = par_on & (par_q != par_exp);
            st_d       = S_IDLE;
          end else begin
            sub_d = sub_q + 1'b1;
          end
        end
      end
      default: st_d = S_IDLE;
    endcase
    if (!en) begin
      st_d   = S_IDLE;
      done_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      sub_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      par_q  <= 1'b0;
      done_q <= 1'b0;
      res_q  <= '0;
      sy1_q  <= 1'b1;
      sy2_q  <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      st_q   <= st_d;
      sub_q  <= sub_d;
      bit_q  <= bit_d;
      sh_q   <= sh_d;
      par_q  <= par_d;
      done_q <= done_d;
      res_q  <= res_d;
      sy1_q  <= line_in;
      sy2_q  <= sy1_q;
      prev_q <= sy2_q;
    end
  end

  assign done   = done_q;
  assign result = res_q;

endmodule

// File: rtl/srx_queue.sv
module srx_queue
  import srx_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       flush,
  input  logic       push,
  input  srx_entry_t wdata,
  input  logic       pop,
  output srx_entry_t head,
  output logic       empty,
  output logic       full
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] PMAX = PW'(DEPTH - 1);
  localparam logic [CW-1:0] CMAX = CW'(DEPTH);

  srx_entry_t    slot_q [DEPTH];
  logic [PW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CMAX);
  assign do_push = push & ~full & ~flush;
  assign do_pop  = pop & ~empty & ~flush;
  assign head    = slot_q[rp_q];

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (do_push) wp_d = (wp_q == PMAX) ? '0 : wp_q + 1'b1;
    if (do_pop)  rp_d = (rp_q == PMAX) ? '0 : rp_q + 1'b1;
    case ({do_push, do_pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
    if (flush) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q[g] <= '0;
      end else if (do_push && (wp_q == PW'(g))) begin
        slot_q[g] <= wdata;
      end
    end
  end

endmodule

// File: rtl/serial_rx_unit.sv
module serial_rx_unit
  import srx_pkg::*;
#(
  parameter int QUEUE_DEPTH = 2,
  parameter int OSR         = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       os_tick,
  input  logic       rx_line,
  input  logic       rx_enable,
  input  logic [2:0] size_code,
  input  logic [1:0] parity_sel,
  input  logic       rd_pop,
  output logic [7:0] rx_byte,
  output logic       rx_bit8,
  output logic       frame_err,
  output logic       parity_err,
  output logic       overrun,
  output logic       rx_ready,
  output logic       pin_claimed
);

  logic       frame_done;
  srx_entry_t frame_res;
  srx_entry_t head;
  logic       q_empty, q_full;
  logic       ovr_q, ovr_d;
  logic       pop_ok;

  srx_sampler #(.OSR(OSR)) u_samp (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (rx_enable),
    .tick       (os_tick),
    .line_in    (rx_line),
    .size_code  (size_code),
    .parity_sel (parity_sel),
    .done       (frame_done),
    .result     (frame_res)
  );

  srx_queue #(.DEPTH(QUEUE_DEPTH)) u_q (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (~rx_enable),
    .push  (frame_done),
    .wdata (frame_res),
    .pop   (rd_pop),
    .head  (head),
    .empty (q_empty),
    .full  (q_full)
  );

  assign pop_ok = rd_pop & ~q_empty;

  always_comb begin
    ovr_d = ovr_q;
    if (pop_ok)                ovr_d = 1'b0;
    if (frame_done && q_full && !pop_ok) ovr_d = 1'b1;
    if (!rx_enable)            ovr_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovr_q <= 1'b0;
    else        ovr_q <= ovr_d;
  end

  assign rx_ready    = ~q_empty;
  assign rx_byte     = rx_ready ? head.chr[7:0] : 8'h00;
  assign rx_bit8     = rx_ready & head.chr[8];
  assign frame_err   = rx_ready & head.ferr;
  assign parity_err  = rx_ready & head.perr;
  assign overrun     = ovr_q;
  assign pin_claimed = rx_enable;

endmodule

// File: rtl/serial_rx_unit_chk.sv
module serial_rx_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_enable,
  input logic       rd_pop,
  input logic       frame_done,
  input logic [7:0] rx_byte,
  input logic       frame_err,
  input logic       parity_err,
  input logic       overrun,
  input logic       rx_ready
);

  // R8
  disabled_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_enable |=> !rx_ready);

  // R8
  disabled_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_enable |=> !(frame_err || parity_err || overrun));

  // R7
  overrun_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(rx_ready));

  // R6
  ready_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_ready) |-> ($past(rd_pop) || !$past(rx_enable)));

  // R5
  ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ready) |-> $past(frame_done));

  // R6
  head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ready && $past(rx_ready) && !$past(rd_pop) && $past(rx_enable))
      |-> $stable(rx_byte));

endmodule

bind serial_rx_unit serial_rx_unit_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rx_enable  (rx_enable),
  .rd_pop     (rd_pop),
  .frame_done (frame_done),
  .rx_byte    (rx_byte),
  .frame_err  (frame_err),
  .parity_err (parity_err),
  .overrun    (overrun),
  .rx_ready   (rx_ready)
);

// File: tb/serial_rx_unit_test.sv
module serial_rx_unit_test;

  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int BIT_CLKS   = 16 * TICK_DIV;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       os_tick = 1'b0;
  logic       rx_line;
  logic       rx_enable;
  logic [2:0] size_code;
  logic [1:0] parity_sel;
  logic       rd_pop;
  logic [7:0] rx_byte;
  logic       rx_bit8, frame_err, parity_err, overrun, rx_ready, pin_claimed;

  int checks = 0;
  int errors = 0;
  int tdiv   = 0;

  serial_rx_unit uut (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_line(rx_line),
    .rx_enable(rx_enable), .size_code(size_code), .parity_sel(parity_sel),
    .rd_pop(rd_pop), .rx_byte(rx_byte), .rx_bit8(rx_bit8),
    .frame_err(frame_err), .parity_err(parity_err), .overrun(overrun),
    .rx_ready(rx_ready), .pin_claimed(pin_claimed)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    tdiv    <= (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
    os_tick <= (tdiv == 0);
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int width_of(input logic [2:0] c);
    case (c)
      3'd0: return 5;
      3'd1: return 6;
      3'd2: return 7;
      3'd7: return 9;
      default: return 8;
    endcase
  endfunction

  function automatic logic [8:0] mask_chr(input logic [8:0] d, input logic [2:0] c);
    return d & 9'((1 << width_of(c)) - 1);
  endfunction

  task automatic wait_bits(input int n);
    repeat (n * BIT_CLKS) @(negedge clk);
  endtask

  task automatic send(input logic [8:0] d, input logic bad_par, input logic bad_stop);
    logic [8:0] m;
    m = mask_chr(d, size_code);
    @(negedge clk); rx_line = 1'b0; wait_bits(1);
    for (int i = 0; i < width_of(size_code); i++) begin
      rx_line = m[i]; wait_bits(1);
    end
    if (parity_sel[1]) begin
      rx_line = (^m) ^ parity_sel[0] ^ bad_par; wait_bits(1);
    end
    rx_line = ~bad_stop; wait_bits(1);
    rx_line = 1'b1; wait_bits(1);
  endtask

  task automatic read_check(input string req, input logic [8:0] d, input logic fe, input logic pe);
    logic [8:0] m;
    m = mask_chr(d, size_code);
    check({req, " ready"}, int'(rx_ready), 1);
    check({req, " low byte"}, int'(rx_byte), int'(m[7:0]));
    check({req, " bit8"}, int'(rx_bit8), int'(m[8]));
    check({req, " frame_err"}, int'(frame_err), int'(fe));
    check({req, " parity_err"}, int'(parity_err), int'(pe));
    rd_pop = 1'b1; @(negedge clk); rd_pop = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [2:0] codes [5];
    void'($urandom(32'h5EED_0042));
    codes = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd7};
    rst_n = 1'b0; rx_line = 1'b1; rx_enable = 1'b0;
    size_code = 3'd3; parity_sel = 2'd0; rd_pop = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R5 reset ready", int'(rx_ready), 0);
    check("R8 reset flags", int'({frame_err, parity_err, overrun}), 0);
    check("R9 idle pin", int'(pin_claimed), 0);
    rx_enable = 1'b1;
    @(negedge clk);
    check("R9 claimed", int'(pin_claimed), 1);

    // R2 each size code, no parity
    foreach (codes[k]) begin
      size_code = codes[k];
      send(9'h1A5, 1'b0, 1'b0);
      read_check("R2 size", 9'h1A5, 1'b0, 1'b0);
      check("R5 empty after pop", int'(rx_ready), 0);
    end

    // R3 parity modes, incl. reserved value 1 as none
    size_code = 3'd7;
    for (int p = 0; p < 4; p++) begin
      parity_sel = 2'(p);
      send(9'h0F3, 1'b1, 1'b0);
      read_check("R3 bad parity", 9'h0F3, 1'b0, p >= 2);
      send(9'h13C, 1'b0, 1'b0);
      read_check("R3 good parity", 9'h13C, 1'b0, 1'b0);
    end

    // R4 frame error
    parity_sel = 2'd0; size_code = 3'd3;
    send(9'h055, 1'b0, 1'b1);
    read_check("R4 stop low", 9'h055, 1'b1, 1'b0);

    // R1 glitch rejection
    @(negedge clk); rx_line = 1'b0;
    repeat (3 * TICK_DIV) @(negedge clk);
    rx_line = 1'b1; wait_bits(12);
    check("R1 glitch ignored", int'(rx_ready), 0);

    // R6 pop on empty queue has no effect
    rd_pop = 1'b1; @(negedge clk); rd_pop = 1'b0;
    send(9'h0A1, 1'b0, 1'b0);
    read_check("R6 after empty pop", 9'h0A1, 1'b0, 1'b0);

    // R7 overrun
    send(9'h011, 1'b0, 1'b0);
    send(9'h022, 1'b0, 1'b0);
    check("R7 no overrun when just full", int'(overrun), 0);
    send(9'h033, 1'b0, 1'b0);
    check("R7 overrun set", int'(overrun), 1);
    read_check("R7 first kept", 9'h011, 1'b0, 1'b0);
    check("R7 overrun cleared by pop", int'(overrun), 0);
    read_check("R7 second kept", 9'h022, 1'b0, 1'b0);
    check("R7 dropped frame absent", int'(rx_ready), 0);

    // R8 flush on disable
    parity_sel = 2'd2;
    send(9'h0C7, 1'b1, 1'b1);
    send(9'h0C8, 1'b0, 1'b0);
    send(9'h0C9, 1'b0, 1'b0);
    check("R8 pre-flush ready", int'(rx_ready), 1);
    check("R8 pre-flush overrun", int'(overrun), 1);
    rx_enable = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R8 flushed", int'(rx_ready), 0);
    check("R8 flags zero", int'({frame_err, parity_err, overrun, rx_bit8}), 0);
    check("R8 byte zero", int'(rx_byte), 0);
    check("R9 released", int'(pin_claimed), 0);
    send(9'h0AA, 1'b0, 1'b0);
    check("R8 disabled ignores line", int'(rx_ready), 0);
    rx_enable = 1'b1;
    @(negedge clk);
    check("R8 empty after re-enable", int'(rx_ready), 0);
    send(9'h05A, 1'b0, 1'b0);
    read_check("R8 after re-enable", 9'h05A, 1'b0, 1'b0);

    // random frames
    for (int n = 0; n < 24; n++) begin
      logic [8:0] d;
      logic bp, bs;
      size_code  = codes[$urandom_range(4, 0)];
      parity_sel = 2'($urandom_range(3, 0));
      d  = 9'($urandom);
      bp = ($urandom_range(3, 0) == 0);
      bs = ($urandom_range(5, 0) == 0);
      send(d, bp, bs);
      read_check("R2 R3 R4 random", d, bs, bp & parity_sel[1]);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule